// File: doc/BRIEF.md
# Pipelined Arg-Min / Arg-Max Reduction Tree

This block reduces one unsigned score per processing element to a single winner. A start pulse captures a flat bus of per-element scores together with a per-element participation mask and a mode bit. A binary comparison tree then picks the smallest score, or the largest in maximum mode. The tree carries both the winning score and the position of the element that produced it. This is the last step of a nearest-neighbour search: the scores are distances, and the host wants the closest exemplar together with its number.

Each tree level is one registered pipeline stage, so a result appears log2(N) cycles after its start. A new start may be issued on every cycle, and each one carries its own mode through the pipe. At every comparison node the lower-numbered side wins ties. The reported position is therefore the lowest-numbered participating element that holds the extreme value. If no element participates, the result is flagged as not valid and reads as zero.

Top module: `amin_reduce`

## Requirements
- R1: With `mode_max` = 0 at start, the result value equals the smallest score among elements whose enable bit is 1. Element i's score is `elem_val[i*W +: W]`.
- R2: With `mode_max` = 1 at start, the result value equals the largest score among enabled elements.
- R3: `best_idx` is the lowest element number i that is enabled and whose score equals the reported value, so equal scores resolve toward element 0.
- R4: `done` is high for exactly one cycle, LVL = log2(N) cycles after the cycle in which `start` is high. Starts on consecutive cycles each give their own result on consecutive cycles, each with the mode it was started with.
- R5: An element whose `elem_en` bit is 0 never wins, even when its score is the most extreme on the bus.
- R6: When no enable bit is set at start, the result has `valid` = 0, `best_val` = 0 and `best_idx` = 0. Otherwise `valid` = 1.
- R7: `valid`, `best_val` and `best_idx` change only in a cycle where `done` is high. Changes on the inputs while `start` is low have no effect on them.
- R8: After synchronous reset, `done`, `valid`, `best_val` and `best_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture the score bus and launch a reduction |
| mode_max | input | 1 | 0 selects minimum, 1 selects maximum |
| elem_en | input | N | Per-element participation mask |
| elem_val | input | N*W | Flat score bus, element i at bits i*W +: W |
| done | output | 1 | One-cycle result strobe |
| valid | output | 1 | At least one element participated |
| best_val | output | W | Winning score |
| best_idx | output | log2(N) | Number of the winning element |

## Verification
Each comparison node's registered output is checked against the two candidates it saw one cycle earlier. A wrong pick, a broken tie or a leaked disabled element is therefore caught at the level where it happens, one cycle after it is made. At the ports, a corrupted stage shows up as a wrong value or index exactly log2(N) cycles after the start that fed it. A broken valid chain shows up as a `done` strobe in the wrong cycle, or as outputs that move without a strobe. The bench model therefore checks `done` on every cycle and checks that the outputs hold between strobes. It drives back-to-back starts with mixed modes, tied scores, and winners at both ends of the bus.

// File: rtl/amin_pkg.sv
package amin_pkg;

  typedef enum logic {
    SEL_MIN = 1'b0,
    SEL_MAX = 1'b1
  } sel_mode_e;

endpackage

// File: rtl/amin_leaf.sv
module amin_leaf #(
  parameter int N  = 32,
  parameter int W  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]            en,
  input  logic [N*W-1:0]          vals,
  output logic [N*(1+IW+W)-1:0]   cands
);
  localparam int CW = 1 + IW + W;

  typedef struct packed {
    logic          ok;
    logic [IW-1:0] idx;
    logic [W-1:0]  val;
  } cand_t;

  // Each element becomes a candidate tagged with its own position
  for (genvar i = 0; i < N; i++) begin : g_pack
    cand_t c;
    assign c.ok  = en[i];
    assign c.idx = IW'(i);
    assign c.val = vals[i*W +: W];
    assign cands[i*CW +: CW] = c;
  end

endmodule

// File: rtl/amin_node.sv
module amin_node import amin_pkg::*; #(
  parameter int W  = 16,
  parameter int IW = 5
) (
  input  sel_mode_e           mode,
  input  logic [IW+W:0]       a,   // lower-numbered side
  input  logic [IW+W:0]       b,   // higher-numbered side
  output logic [IW+W:0]       y
);
  typedef struct packed {
    logic          ok;
    logic [IW-1:0] idx;
    logic [W-1:0]  val;
  } cand_t;

  cand_t ca, cb, cy;
  logic  b_beats;

  assign ca = a;
  assign cb = b;

  // b wins only on a strict improvement, so ties stay on the low side
  always_comb begin
    if (mode == SEL_MAX) b_beats = cb.val > ca.val;
    else                 b_beats = cb.val < ca.val;
  end

  always_comb begin
    if (!ca.ok && !cb.ok)          cy = '0;
    else if (cb.ok && (!ca.ok || b_beats)) cy = cb;
    else                           cy = ca;
  end

  assign y = cy;

endmodule

// File: rtl/amin_stage.sv
module amin_stage import amin_pkg::*; #(
  parameter int W   = 16,
  parameter int IW  = 5,
  parameter int NIN = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_vld,
  input  sel_mode_e                         in_mode,
  input  logic [NIN*(1+IW+W)-1:0]           in_cands,
  output logic                              out_vld,
  output sel_mode_e                         out_mode,
  output logic [(NIN/2)*(1+IW+W)-1:0]       out_cands
);
  localparam int CW   = 1 + IW + W;
  localparam int NOUT = NIN / 2;

  typedef struct packed {
    logic          ok;
    logic [IW-1:0] idx;
    logic [W-1:0]  val;
  } cand_t;

  logic [NOUT*CW-1:0] nxt;
  cand_t              cin [NIN];
  cand_t              cq  [NOUT];

  for (genvar i = 0; i < NIN; i++) begin : g_view_in
    assign cin[i] = in_cands[i*CW +: CW];
  end

  for (genvar j = 0; j < NOUT; j++) begin : g_node
    amin_node #(.W(W), .IW(IW)) u_node (
      .mode (in_mode),
      .a    (in_cands[(2*j)*CW   +: CW]),
      .b    (in_cands[(2*j+1)*CW +: CW]),
      .y    (nxt[j*CW +: CW])
    );
    assign cq[j] = out_cands[j*CW +: CW];
  end

  // Data registers load only when a reduction passes through
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_mode  <= SEL_MIN;
      out_cands <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_mode  <= in_mode;
        out_cands <= nxt;
      end
    end
  end

  for (genvar j = 0; j < NOUT; j++) begin : g_chk
    p_min_pick_r1: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_mode == SEL_MIN && cin[2*j].ok && cin[2*j+1].ok) |=>
        (cq[j].val <= $past(cin[2*j].val) && cq[j].val <= $past(cin[2*j+1].val)));

    p_max_pick_r2: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_mode == SEL_MAX && cin[2*j].ok && cin[2*j+1].ok) |=>
        (cq[j].val >= $past(cin[2*j].val) && cq[j].val >= $past(cin[2*j+1].val)));

    p_tie_low_r3: assert property (@(posedge clk) disable iff (rst)
      (in_vld && cin[2*j].ok && cin[2*j+1].ok && cin[2*j].val == cin[2*j+1].val) |=>
        (cq[j].idx == $past(cin[2*j].idx)));

    p_skip_off_r5: assert property (@(posedge clk) disable iff (rst)
      (in_vld && (cin[2*j].ok != cin[2*j+1].ok)) |=>
        (cq[j].ok && cq[j].idx == ($past(cin[2*j].ok) ? $past(cin[2*j].idx) : $past(cin[2*j+1].idx))));

    p_none_zero_r6: assert property (@(posedge clk) disable iff (rst)
      (in_vld && !cin[2*j].ok && !cin[2*j+1].ok) |=> (cq[j] == '0));
  end

endmodule

// File: rtl/amin_reduce.sv
module amin_reduce import amin_pkg::*; #(
  parameter int N  = 32,
  parameter int W  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode_max,
  input  logic [N-1:0]     elem_en,
  input  logic [N*W-1:0]   elem_val,
  output logic             done,
  output logic             valid,
  output logic [W-1:0]     best_val,
  output logic [IW-1:0]    best_idx
);
  localparam int LVL = $clog2(N);
  localparam int CW  = 1 + IW + W;

  typedef struct packed {
    logic          ok;
    logic [IW-1:0] idx;
    logic [W-1:0]  val;
  } cand_t;

  logic [N*CW-1:0] leaf_c;
  cand_t           fin;

  amin_leaf #(.N(N), .W(W), .IW(IW)) u_leaf (
    .en    (elem_en),
    .vals  (elem_val),
    .cands (leaf_c)
  );

  for (genvar l = 0; l < LVL; l++) begin : g_lvl
    localparam int NIN = N >> l;
    logic [NIN*CW-1:0]     cin;
    logic                  vin;
    sel_mode_e             min_;
    logic [(NIN/2)*CW-1:0] cout;
    logic                  vout;
    sel_mode_e             mout;

    if (l == 0) begin : g_first
      assign cin  = leaf_c;
      assign vin  = start;
      assign min_ = sel_mode_e'(mode_max);
    end else begin : g_next
      assign cin  = g_lvl[l-1].cout;
      assign vin  = g_lvl[l-1].vout;
      assign min_ = g_lvl[l-1].mout;
    end

    amin_stage #(.W(W), .IW(IW), .NIN(NIN)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .in_vld    (vin),
      .in_mode   (min_),
      .in_cands  (cin),
      .out_vld   (vout),
      .out_mode  (mout),
      .out_cands (cout)
    );
  end

  assign fin      = g_lvl[LVL-1].cout;
  assign done     = g_lvl[LVL-1].vout;
  assign valid    = fin.ok;
  assign best_val = fin.val;
  assign best_idx = fin.idx;

  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start, LVL));

  p_mode_follows_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (g_lvl[LVL-1].mout == sel_mode_e'($past(mode_max, LVL))));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(best_val) && $stable(best_idx) && $stable(valid)));

  p_empty_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !valid) |-> (best_val == '0 && best_idx == '0));

endmodule

// File: tb/amin_reduce_bench.sv
`timescale 1ns/1ps
module amin_reduce_bench;
  localparam int N   = 32;
  localparam int W   = 16;
  localparam int IW  = $clog2(N);
  localparam int LVL = $clog2(N);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic           mode_max = 1'b0;
  logic [N-1:0]   elem_en = '0;
  logic [N*W-1:0] elem_val = '0;
  logic           done, valid;
  logic [W-1:0]   best_val;
  logic [IW-1:0]  best_idx;

  always #2 clk = ~clk;

  amin_reduce #(.N(N), .W(W)) u_amin_reduce (
    .clk(clk), .rst(rst), .start(start), .mode_max(mode_max),
    .elem_en(elem_en), .elem_val(elem_val),
    .done(done), .valid(valid), .best_val(best_val), .best_idx(best_idx)
  );

  typedef struct {
    int          due;
    logic        ok;
    logic [W-1:0] v;
    int          idx;
    string       tag;
  } exp_t;

  exp_t         q[$];
  int           cyc = 0;
  int           n_chk = 0;
  int           n_fail = 0;
  logic [W-1:0] last_v = '0;
  int           last_i = 0;
  logic         last_ok = 1'b0;
  bit           finished = 1'b0;
  string        cur_tag = "R1";

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Behavioural model: plain linear scan, strict improvement keeps the first
  function automatic exp_t model(input logic [N*W-1:0] v, input logic [N-1:0] e, input logic m);
    exp_t r;
    r.ok = 1'b0; r.v = '0; r.idx = 0; r.due = 0; r.tag = "";
    for (int i = 0; i < N; i++) begin
      if (e[i]) begin
        logic [W-1:0] s;
        s = v[i*W +: W];
        if (!r.ok || (m ? (s > r.v) : (s < r.v))) begin
          r.ok = 1'b1; r.v = s; r.idx = i;
        end
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) cyc = 0;
    else begin
      cyc = cyc + 1;
      if (start) begin
        exp_t e;
        e = model(elem_val, elem_en, mode_max);
        e.due = cyc + LVL - 1;
        e.tag = cur_tag;
        q.push_back(e);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit due_now;
      due_now = (q.size() > 0) && (q[0].due == cyc);
      chk("R4", "done strobe", done, due_now);
      if (due_now) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "valid", valid, e.ok);
        chk(e.tag, "best_val", best_val, e.v);
        chk(e.tag, "best_idx", best_idx, e.idx);
        last_v = e.v; last_i = e.idx; last_ok = e.ok;
      end else begin
        chk("R7", "held best_val", best_val, last_v);
        chk("R7", "held best_idx", best_idx, last_i);
        chk("R7", "held valid", valid, last_ok);
      end
    end
  end

  task automatic fire(input logic [N*W-1:0] v, input logic [N-1:0] e, input logic m, input string tag);
    @(negedge clk);
    elem_val = v; elem_en = e; mode_max = m; cur_tag = tag; start = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < N; i++) elem_val[i*W +: W] = W'($urandom);
      elem_en  = N'($urandom);
      mode_max = 1'($urandom);
    end
  endtask

  function automatic logic [N*W-1:0] spread(input int base, input int span);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(base + ($urandom % span));
    return v;
  endfunction

  initial begin
    logic [N*W-1:0] v;
    logic [N-1:0]   all_on;
    all_on = '1;

    repeat (3) @(negedge clk);
    chk("R8", "reset done", done, 0);
    chk("R8", "reset valid", valid, 0);
    chk("R8", "reset best_val", best_val, 0);
    chk("R8", "reset best_idx", best_idx, 0);
    rst = 1'b0;
    idle(2);

    // all scores equal: element 0 must win in both modes
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(7);
    fire(v, all_on, 1'b0, "R3");
    fire(v, all_on, 1'b1, "R3");
    idle(LVL + 2);

    // extreme at element 0 and at the last element
    v = spread(100, 1000); v[0 +: W] = W'(5);
    fire(v, all_on, 1'b0, "R1");
    v = spread(100, 1000); v[(N-1)*W +: W] = W'(3);
    fire(v, all_on, 1'b0, "R1");
    v = spread(100, 1000); v[(N-1)*W +: W] = W'(60000);
    fire(v, all_on, 1'b1, "R2");
    v = spread(100, 1000); v[0 +: W] = W'(60000);
    fire(v, all_on, 1'b1, "R2");
    idle(LVL + 2);

    // duplicate minimum at 3 and 20, duplicate maximum at 11 and 30
    v = spread(200, 500); v[3*W +: W] = W'(9); v[20*W +: W] = W'(9);
    fire(v, all_on, 1'b0, "R3");
    v = spread(200, 500); v[11*W +: W] = W'(900); v[30*W +: W] = W'(900);
    fire(v, all_on, 1'b1, "R3");
    idle(LVL + 2);

    // disabled extremes must be skipped
    v = spread(10, 500); v[4*W +: W] = '0; v[9*W +: W] = W'(10);
    fire(v, all_on & ~(N'(1) << 4), 1'b0, "R5");
    v = spread(10, 500); v[7*W +: W] = '1;
    fire(v, all_on & ~(N'(1) << 7), 1'b1, "R5");
    v = spread(0, 65535);
    fire(v, N'(1) << (N-1), 1'b0, "R5");
    idle(LVL + 2);

    // nothing enabled
    fire(spread(0, 65535), '0, 1'b0, "R6");
    fire(spread(0, 65535), '0, 1'b1, "R6");
    idle(LVL + 4);

    // random stream, back-to-back with occasional gaps
    for (int k = 0; k < 400; k++) begin
      logic           m;
      logic [N-1:0]   e;
      int             sel;
      m = 1'($urandom);
      sel = $urandom % 16;
      if (sel == 0)      e = '0;
      else if (sel < 5)  e = N'($urandom);
      else               e = all_on;
      if (($urandom % 3) == 0) v = spread(0, 4);
      else                     v = spread(0, 65536);
      fire(v, e, m, (sel == 0) ? "R6" : (sel < 5) ? "R5" : (m ? "R2" : "R1"));
      if (($urandom % 8) == 0) idle(1 + ($urandom % (LVL + 2)));
    end
    idle(LVL + 4);

    chk("R4", "pending results drained", q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog: actual cycle %0d expected completion earlier", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule